// File: doc/BRIEF.md
# Self-Test Frame Generator for Four Bit-Interleaved Lanes

This block produces a built-in self-test stream for a four-lane parallel interface that is later bit-interleaved onto a serial line. Each frame it emits is a fixed framing header followed by a pseudo-random payload. One generator forms a single bit stream, and every lane carries a copy of that stream. Each lane lags its lower-numbered neighbour by one lane clock cycle. A downstream frame detector and deinterleaver can therefore lock onto the stream and check its channel assignment.

The block runs while the active-low self-test input is low. While it runs, it replaces the normal lane inputs at the lane outputs. When self-test is off, the lane inputs reach the outputs unchanged in the same cycle. An active-low frame restart input returns the header position and the pseudo-random generator to their start values. Leaving self-test has the same effect, so every new self-test session begins at the start of a frame.

Top module: `bist_frame_gen`

## Requirements
- R1: With `selftest_n` low, a frame on lane 0 opens with 12 bytes of value 0xF6. Each byte is sent most significant bit first, one bit per cycle. The first bit of the frame appears on lane 0 after the first clock edge at which `selftest_n` is low and `frame_restart_n` is high.
- R2: The 12 header bytes of value 0xF6 are followed by 12 bytes of value 0x28, also sent most significant bit first.
- R3: The remaining 9696 bytes of the frame are payload. The payload bit is bit 6 of a 7-bit register with seed 0x7F. On every payload bit the register shifts left and takes bit6 XOR bit5 into bit 0, which implements x^7+x^6+1. The register is never all zeros.
- R4: A frame is 9720 bytes (77760 bits) long. The next frame starts again with the 0xF6 bytes.
- R5: The payload register holds its value during header bits and is not reseeded at a frame boundary. The payload of the next frame continues the sequence where the previous frame stopped.
- R6: Lane k (k = 1..3) outputs the bit that lane k-1 showed one cycle earlier.
- R7: With `selftest_n` high, `lane_out` equals `lane_in` in the same cycle.
- R8: With `selftest_n` low, `lane_in` has no effect on `lane_out`.
- R9: A clock edge that samples `frame_restart_n` low, with `selftest_n` low, sets lane 0 to 1. It also returns the frame position and the payload register to their start values. The first edge after release emits bit 0 of a new frame.
- R10: While `rst` is high and `selftest_n` is low, all lane outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| selftest_n | input | 1 | Active-low self-test enable |
| frame_restart_n | input | 1 | Active-low restart of the frame position and the pseudo-random sequence |
| lane_in | input | LANES | Normal lane bits, one per lane |
| lane_out | output | LANES | Lane bits driven toward the interleaver |

## Verification
A full frame and the start of the next one run with random values on `lane_in`, and a reference model predicts every bit on every lane. This run separates header bytes sent with the wrong bit order from a payload polynomial or seed that is wrong. It also catches a frame length that is off by one byte and a payload register that is reseeded at the wrap. Comparing lanes 1 to 3 against delayed copies of the lane 0 prediction exposes a wrong lane stagger. A restart pulse in the middle of a frame shows whether both the header position and the payload register return to their start values. Fixed `lane_in` values with self-test off, and a `lane_in` flip with self-test on, confirm the output selection in both directions.

// File: rtl/bist_frame_pkg.sv
package bist_frame_pkg;

    localparam int unsigned PRBS_W = 7;

    typedef enum logic [1:0] {
        SEG_A1  = 2'd0,
        SEG_A2  = 2'd1,
        SEG_PAY = 2'd2
    } seg_e;

    typedef struct packed {
        seg_e       seg;
        logic [2:0] bit_idx;
    } frame_pos_t;

    // One step of the x^7 + x^6 + 1 sequence (shift left, feedback into bit 0)
    function automatic logic [PRBS_W-1:0] prbs7_next(input logic [PRBS_W-1:0] s);
        return {s[PRBS_W-2:0], s[6] ^ s[5]};
    endfunction

endpackage

// File: rtl/bist_frame_pos.sv
module bist_frame_pos
    import bist_frame_pkg::*;
#(
    parameter int unsigned FRAME_BYTES = 9720,
    parameter int unsigned A1_BYTES    = 12,
    parameter int unsigned A2_BYTES    = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    output frame_pos_t pos
);
    localparam int unsigned BYTE_W = $clog2(FRAME_BYTES);
    localparam logic [BYTE_W-1:0] A1_END   = BYTE_W'(A1_BYTES);
    localparam logic [BYTE_W-1:0] HDR_END  = BYTE_W'(A1_BYTES + A2_BYTES);
    localparam logic [BYTE_W-1:0] LAST_BYT = BYTE_W'(FRAME_BYTES - 1);

    logic [2:0]        bit_q;
    logic [BYTE_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            bit_q  <= '0;
            byte_q <= '0;
        end else begin
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
                byte_q <= (byte_q == LAST_BYT) ? '0 : byte_q + 1'b1;
            end
        end
    end

    always_comb begin
        pos.bit_idx = bit_q;
        if (byte_q < A1_END)       pos.seg = SEG_A1;
        else if (byte_q < HDR_END) pos.seg = SEG_A2;
        else                       pos.seg = SEG_PAY;
    end
endmodule

// File: rtl/bist_prbs7.sv
module bist_prbs7
    import bist_frame_pkg::*;
#(
    parameter logic [PRBS_W-1:0] SEED = 7'h7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              adv,
    output logic              bit_out,
    output logic [PRBS_W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state <= SEED;
        end else if (adv) begin
            state <= prbs7_next(state);
        end
    end

    assign bit_out = state[PRBS_W-1];
endmodule

// File: rtl/bist_lane_skew.sv
module bist_lane_skew #(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [LANES-1:0] taps
);
    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_stage
            if (k == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) taps[0] <= 1'b0;
                    else     taps[0] <= din;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) taps[k] <= 1'b0;
                    else     taps[k] <= taps[k-1];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bist_frame_gen.sv
module bist_frame_gen
    import bist_frame_pkg::*;
#(
    parameter int unsigned       LANES       = 4,
    parameter int unsigned       FRAME_BYTES = 9720,
    parameter int unsigned       A1_BYTES    = 12,
    parameter int unsigned       A2_BYTES    = 12,
    parameter logic [7:0]        A1_VAL      = 8'hF6,
    parameter logic [7:0]        A2_VAL      = 8'h28,
    parameter logic [PRBS_W-1:0] PRBS_SEED   = 7'h7F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             selftest_n,
    input  logic             frame_restart_n,
    input  logic [LANES-1:0] lane_in,
    output logic [LANES-1:0] lane_out
);
    logic              run;
    frame_pos_t        pos;
    logic              in_hdr;
    logic              hdr_bit;
    logic              prbs_bit;
    logic [PRBS_W-1:0] prbs_state;
    logic              stream_bit;
    logic [LANES-1:0]  taps;

    assign run = !selftest_n && frame_restart_n;

    bist_frame_pos #(
        .FRAME_BYTES (FRAME_BYTES),
        .A1_BYTES    (A1_BYTES),
        .A2_BYTES    (A2_BYTES)
    ) u_pos (
        .clk (clk),
        .rst (rst),
        .run (run),
        .pos (pos)
    );

    assign in_hdr = (pos.seg != SEG_PAY);

    bist_prbs7 #(
        .SEED (PRBS_SEED)
    ) u_prbs (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .adv     (!in_hdr),
        .bit_out (prbs_bit),
        .state   (prbs_state)
    );

    always_comb begin
        if (pos.seg == SEG_A1) hdr_bit = A1_VAL[3'd7 - pos.bit_idx];
        else                   hdr_bit = A2_VAL[3'd7 - pos.bit_idx];
        // While idle or restarting, feed the first frame bit so lanes rest at it
        if (!run)        stream_bit = A1_VAL[7];
        else if (in_hdr) stream_bit = hdr_bit;
        else             stream_bit = prbs_bit;
    end

    bist_lane_skew #(
        .LANES (LANES)
    ) u_skew (
        .clk  (clk),
        .rst  (rst),
        .din  (stream_bit),
        .taps (taps)
    );

    assign lane_out = selftest_n ? lane_in : taps;
endmodule

// File: rtl/bist_frame_gen_chk.sv
module bist_frame_gen_chk #(
    parameter int unsigned LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             selftest_n,
    input logic             frame_restart_n,
    input logic             run,
    input logic             in_hdr,
    input logic [6:0]       prbs_state,
    input logic [LANES-1:0] lane_out
);
    // R3: the payload register never reaches the all-zero lock-up state
    p_lfsr_live_r3: assert property (@(posedge clk) disable iff (rst)
        prbs_state != 7'd0);

    // R5: header bits leave the payload register untouched
    p_hdr_hold_prbs_r5: assert property (@(posedge clk) disable iff (rst)
        (run && in_hdr) |=> $stable(prbs_state));

    // R1: after any idle or restart edge, the frame position is in the header
    p_restart_hdr_r1: assert property (@(posedge clk) disable iff (rst)
        !run |=> in_hdr);

    // R9: a restart edge in self-test leaves lane 0 at 1
    p_restart_mark_r9: assert property (@(posedge clk) disable iff (rst)
        (!frame_restart_n && !selftest_n) |=> (selftest_n || lane_out[0]));

    genvar k;
    generate
        for (k = 1; k < LANES; k++) begin : g_stag
            // R6: each lane repeats its lower neighbour one cycle later
            p_stagger_r6: assert property (@(posedge clk) disable iff (rst)
                (!selftest_n && $past(!selftest_n) && !$past(rst))
                |-> lane_out[k] == $past(lane_out[k-1]));
        end
    endgenerate
endmodule

bind bist_frame_gen bist_frame_gen_chk #(
    .LANES (LANES)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .selftest_n      (selftest_n),
    .frame_restart_n (frame_restart_n),
    .run             (run),
    .in_hdr          (in_hdr),
    .prbs_state      (prbs_state),
    .lane_out        (lane_out)
);

// File: tb/tb_bist_frame_gen.sv
module tb_bist_frame_gen;
    localparam int CLK_P      = 10;
    localparam int LANES      = 4;
    localparam int FRAME_BITS = 9720 * 8;
    localparam int WD_CYCLES  = 190000;

    logic             clk = 1'b0;
    logic             rst;
    logic             selftest_n;
    logic             frame_restart_n;
    logic [LANES-1:0] lane_in;
    logic [LANES-1:0] lane_out;

    int checks = 0;
    int fails  = 0;

    bist_frame_gen dut (
        .clk             (clk),
        .rst             (rst),
        .selftest_n      (selftest_n),
        .frame_restart_n (frame_restart_n),
        .lane_in         (lane_in),
        .lane_out        (lane_out)
    );

    always #(CLK_P/2) clk = ~clk;

    // Reference model state
    int         m_byte, m_bit, m_frame, age;
    logic [6:0] m_lfsr;
    logic [3:0] hist;

    logic [3:0] exp_q[$];
    logic [3:0] mask_q[$];
    string      tag_q[$];

    task automatic model_reset();
        m_byte = 0; m_bit = 0; m_frame = 0; m_lfsr = 7'h7F; age = 0; hist = 4'h0;
    endtask

    task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one lane cycle, pushing the expected lane vector after the coming edge
    task automatic drive_cycle(input logic tn, input logic frn, input logic [3:0] lin, input string tag_over);
        logic [3:0] e, m;
        logic       b;
        string      t;
        @(negedge clk);
        selftest_n = tn; frame_restart_n = frn; lane_in = lin;
        if (!tn) begin
            e = '0; m = '0;
            if (frn) begin
                if (m_byte < 12)      b = 1'(8'hF6 >> (7 - m_bit));
                else if (m_byte < 24) b = 1'(8'h28 >> (7 - m_bit));
                else                  b = m_lfsr[6];
                if (m_frame == 0) t = (m_byte < 12) ? "R1" : (m_byte < 24) ? "R2" : "R3";
                else              t = (m_byte < 24) ? "R4" : "R5";
                hist = {hist[2:0], b};
                age++;
                if (m_byte >= 24) m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
                m_bit++;
                if (m_bit == 8) begin
                    m_bit = 0; m_byte++;
                    if (m_byte == 9720) begin m_byte = 0; m_frame++; end
                end
                for (int k = 0; k < LANES; k++) begin
                    if (age >= k + 1) begin m[k] = 1'b1; e[k] = hist[k]; end
                end
            end else begin
                model_reset();
                e = 4'b0001; m = 4'b0001; t = "R9";
            end
            if (tag_over != "") t = tag_over;
            exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(t);
        end
    endtask

    // Monitor: compare after each edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (exp_q.size() > 0) begin
            logic [3:0] e, m;
            string      t;
            e = exp_q.pop_front(); m = mask_q.pop_front(); t = tag_q.pop_front();
            for (int k = 0; k < LANES; k++) begin
                if (m[k]) begin
                    checks++;
                    if (lane_out[k] !== e[k]) begin
                        fails++;
                        $display("FAIL %s lane %0d actual=%b expected=%b",
                                 (k == 0) ? t : "R6", k, lane_out[k], e[k]);
                    end
                end
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [3:0] held;
        rst = 1'b1; selftest_n = 1'b0; frame_restart_n = 1'b1; lane_in = 4'hF;
        model_reset();
        repeat (3) @(negedge clk);
        check(lane_out == 4'h0, "R10", lane_out, 4'h0);

        // Leave reset with self-test off: pass-through
        rst = 1'b0; selftest_n = 1'b1;
        lane_in = 4'hA; #1 check(lane_out == 4'hA, "R7", lane_out, 4'hA);
        lane_in = 4'h5; #1 check(lane_out == 4'h5, "R7", lane_out, 4'h5);
        @(negedge clk);
        lane_in = 4'h3; #1 check(lane_out == 4'h3, "R7", lane_out, 4'h3);

        // One full frame plus the start of the next, random lane inputs (R1-R6, R8)
        model_reset();
        for (int i = 0; i < FRAME_BITS + 400; i++) drive_cycle(1'b0, 1'b1, 4'($urandom), "");

        // R8: flip lane inputs within a cycle during self-test
        @(posedge clk); #(CLK_P/4 + 1);
        held = lane_out;
        lane_in = ~lane_in; #1 check(lane_out == held, "R8", lane_out, held);
        lane_in = 4'h0;     #1 check(lane_out == held, "R8", lane_out, held);

        // Restart pulse in the middle of a frame (R9)
        for (int i = 0; i < 3; i++)   drive_cycle(1'b0, 1'b0, 4'($urandom), "R9");
        for (int i = 0; i < 300; i++) drive_cycle(1'b0, 1'b1, 4'($urandom), "R9");

        // Back to pass-through
        @(posedge clk); #(CLK_P/4 + 1);
        selftest_n = 1'b1;
        lane_in = 4'h6; #1 check(lane_out == 4'h6, "R7", lane_out, 4'h6);
        lane_in = 4'h9; #1 check(lane_out == 4'h9, "R7", lane_out, 4'h9);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule